// File: doc/BRIEF.md
# Quadrature Position Counter with Event Strobes

This block turns a pair of already-synchronised quadrature phase signals into a signed position count of configurable width. Every transition on either phase moves the count by one (4x decoding). The direction follows the Gray-code order in which the phases change. The count is held in two's complement and wraps at both ends of its signed range.

The block reports three conditions as single-cycle strobes, meant for a status register further up the chip:

- **Decode error.** Both phases change in the same sample, or a transition arrives sooner than a programmable minimum number of clock cycles after the previous one.
- **Overflow.** The count wraps past either end of its signed range.
- **Zero.** A step lands the count on zero.

After a decode error the count freezes. It stays frozen until the host issues the explicit clear command, which also sets the count to zero.

Top module: `qdec_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `count` is zero and all three strobes are low.
- R2: The phase order {A,B} = 00, 10, 11, 01, 00 counts up. Each single-phase change adds one, and the new value appears on `count` in the cycle after the sample that carried the change.
- R3: The reverse order {A,B} = 00, 01, 11, 10, 00 counts down by one per change, with the same one-cycle latency.
- R4: If both phases change in the same sample, `err_evt` pulses for one cycle and `count` keeps its value.
- R5: The spacing of a transition is the number of clock cycles between its sample and the previous transition's sample. A transition with spacing below `min_gap` raises `err_evt` and is not counted; a spacing equal to `min_gap` is counted. The first transition after reset is always accepted.
- R6: Once a decode error has occurred, later transitions leave `count` unchanged and raise no strobes until `clr_cnt` is applied.
- R7: `clr_cnt` sets `count` to zero in the next cycle and ends the frozen state. It takes priority over a transition in the same sample, and it raises no strobe.
- R8: An up step from 2^(n-1)-1 gives -2^(n-1), and a down step from -2^(n-1) gives 2^(n-1)-1. In both cases `ovf_evt` pulses in the same cycle as the wrapped value.
- R9: `zero_evt` pulses for one cycle, together with the new count, whenever a counted step makes the count zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Synchronised phase A |
| phase_b | input | 1 | Synchronised phase B |
| clr_cnt | input | 1 | Counter clear and error recovery command |
| min_gap | input | GAP_W | Minimum transition spacing in clock cycles |
| count | output | CNT_W | Signed position count, two's complement |
| err_evt | output | 1 | Decode error strobe |
| ovf_evt | output | 1 | Range wrap strobe |
| zero_evt | output | 1 | Count reached zero strobe |

## Verification
The phases are driven through full forward and reverse Gray cycles. This tells direction decoding apart from mere edge counting, and a descent through zero exposes the zero strobe. Transitions are placed exactly at the minimum spacing and one cycle inside it, and a dual-phase flip is also driven; together these separate a spacing error from an illegal-transition error and from an off-by-one in the spacing compare. Long runs to both ends of the range, transitions during the frozen state, and a clear that coincides with a transition cover wrap, freeze and clear priority.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;
endpackage

// File: rtl/qdec_phase.sv
module qdec_phase (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    output qdec_pkg::step_e   step_o
);
    import qdec_pkg::*;

    typedef struct packed {
        logic [1:0] ab;
        logic       primed;
    } phase_s;

    phase_s st_d, st_q;
    logic [1:0] cur;

    always_comb begin
        cur          = {phase_a, phase_b};
        st_d.ab      = cur;
        st_d.primed  = 1'b1;
        step_o       = STEP_NONE;
        if (st_q.primed && (cur != st_q.ab)) begin
            if ((cur ^ st_q.ab) == 2'b11)
                step_o = STEP_BAD;
            else if (cur[1] ^ st_q.ab[0])
                step_o = STEP_UP;
            else
                step_o = STEP_DOWN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/qdec_gap.sv
module qdec_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [GAP_W-1:0] min_gap,
    output logic             too_close_o
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        too_close_o = edge_i && (gap_q < min_gap);
        if (edge_i)
            gap_d = {{(GAP_W-1){1'b0}}, 1'b1};
        else if (gap_q != GAP_MAX)
            gap_d = gap_q + 1'b1;
        else
            gap_d = gap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= GAP_MAX;
        else        gap_q <= gap_d;
    end
endmodule

// File: rtl/qdec_accum.sv
module qdec_accum #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  qdec_pkg::step_e   step_i,
    input  logic              too_close_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              err_evt_o,
    output logic              ovf_evt_o,
    output logic              zero_evt_o
);
    import qdec_pkg::*;

    localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             err;
        logic             ovf;
        logic             zero;
    } acc_s;

    acc_s st_d, st_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.ovf  = 1'b0;
        st_d.zero = 1'b0;
        nxt       = st_q.cnt;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.pend = 1'b0;
        end else if (!st_q.pend && step_i != STEP_NONE) begin
            if (step_i == STEP_BAD || too_close_i) begin
                st_d.pend = 1'b1;
                st_d.err  = 1'b1;
            end else begin
                if (step_i == STEP_UP) begin
                    nxt      = st_q.cnt + 1'b1;
                    st_d.ovf = (st_q.cnt == CMAX);
                end else begin
                    nxt      = st_q.cnt - 1'b1;
                    st_d.ovf = (st_q.cnt == CMIN);
                end
                st_d.cnt  = nxt;
                st_d.zero = (nxt == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o    = st_q.cnt;
    assign err_evt_o  = st_q.err;
    assign ovf_evt_o  = st_q.ovf;
    assign zero_evt_o = st_q.zero;

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr_i) |=> ($stable(count_o) && !err_evt_o && !ovf_evt_o && !zero_evt_o));

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !st_q.pend && step_i == STEP_UP && !too_close_i && count_o == CMAX)
        |=> (ovf_evt_o && count_o == CMIN));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0 && !err_evt_o && !ovf_evt_o && !zero_evt_o));

    assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt_o |-> (count_o == '0));

    assert_bad_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !st_q.pend && step_i == STEP_BAD) |=> (err_evt_o && $stable(count_o)));

    assert_one_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_evt_o, ovf_evt_o, zero_evt_o}));
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
    parameter int CNT_W = 16,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             clr_cnt,
    input  logic [GAP_W-1:0] min_gap,
    output logic [CNT_W-1:0] count,
    output logic             err_evt,
    output logic             ovf_evt,
    output logic             zero_evt
);
    import qdec_pkg::*;

    step_e step;
    logic  edge_seen;
    logic  too_close;

    assign edge_seen = (step != STEP_NONE);

    qdec_phase u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_a (phase_a),
        .phase_b (phase_b),
        .step_o  (step)
    );

    qdec_gap #(.GAP_W(GAP_W)) u_gap (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edge_seen),
        .min_gap     (min_gap),
        .too_close_o (too_close)
    );

    qdec_accum #(.CNT_W(CNT_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_cnt),
        .step_i      (step),
        .too_close_i (too_close),
        .count_o     (count),
        .err_evt_o   (err_evt),
        .ovf_evt_o   (ovf_evt),
        .zero_evt_o  (zero_evt)
    );

    assert_close_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cnt && too_close && !err_evt && !$isunknown(count)) |=> ($stable(count) && !ovf_evt && !zero_evt));
endmodule

// File: tb/sim_qdec_counter.sv
`timescale 1ns/1ps
module sim_qdec_counter;
    localparam int W    = 6;
    localparam int GW   = 8;
    localparam int CMAX = 31;
    localparam int CMIN = -32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0, b = 1'b0, clr = 1'b0;
    logic [GW-1:0] mg = 8'd3;
    logic [W-1:0] count;
    logic err_evt, ovf_evt, zero_evt;

    always #2.5 clk = ~clk;

    qdec_counter #(.CNT_W(W), .GAP_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n), .phase_a(a), .phase_b(b), .clr_cnt(clr),
        .min_gap(mg), .count(count), .err_evt(err_evt), .ovf_evt(ovf_evt), .zero_evt(zero_evt)
    );

    typedef struct {
        int    cnt;
        bit    err;
        bit    ovf;
        bit    zero;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    int         m_cnt = 0;
    bit         m_pend = 0;
    bit         m_primed = 0;
    logic [1:0] m_prev = 2'b00;
    int         m_gap = 255;

    task automatic cyc(input logic na, input logic nb, input logic nclr);
        exp_t e;
        logic [1:0] cur;
        bit edge_s, tc;
        @(negedge clk);
        a = na; b = nb; clr = nclr;
        cur = {na, nb};
        e.err = 0; e.ovf = 0; e.zero = 0;
        edge_s = m_primed && (cur != m_prev);
        tc = edge_s && (m_gap < int'(mg));
        m_primed = 1;
        if (nclr) begin
            m_cnt = 0; m_pend = 0;
        end else if (edge_s && !m_pend) begin
            if ((cur ^ m_prev) == 2'b11 || tc) begin
                m_pend = 1; e.err = 1;
            end else if (na ^ m_prev[0]) begin
                if (m_cnt == CMAX) begin m_cnt = CMIN; e.ovf = 1; end
                else m_cnt = m_cnt + 1;
                e.zero = (m_cnt == 0);
            end else begin
                if (m_cnt == CMIN) begin m_cnt = CMAX; e.ovf = 1; end
                else m_cnt = m_cnt - 1;
                e.zero = (m_cnt == 0);
            end
        end
        if (edge_s) m_gap = 1;
        else if (m_gap < 255) m_gap = m_gap + 1;
        m_prev = cur;
        e.cnt = m_cnt;
        e.req = cur_req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(a, b, 1'b0);
    endtask

    task automatic step_up(input int hold);
        cyc(~b, a, 1'b0);
        idle(hold - 1);
    endtask

    task automatic step_dn(input int hold);
        cyc(b, ~a, 1'b0);
        idle(hold - 1);
    endtask

    // monitor: pops one expected item per clock, sampled 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if ($signed(count) != e.cnt || err_evt != e.err || ovf_evt != e.ovf || zero_evt != e.zero) begin
                    errors++;
                    $display("FAIL %s count=%0d exp %0d err=%b exp %b ovf=%b exp %b zero=%b exp %b",
                             e.req, $signed(count), e.cnt, err_evt, e.err, ovf_evt, e.ovf, zero_evt, e.zero);
                end
            end
        end
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            checks++;
            if (count != '0 || err_evt || ovf_evt || zero_evt) begin
                errors++;
                $display("FAIL R1 count=%0d exp 0 strobes=%b%b%b exp 000", count, err_evt, ovf_evt, zero_evt);
            end
            @(negedge clk);
        end
        rst_n = 1'b1;

        cur_req = "R1";
        idle(2);
        cur_req = "R2";
        for (int i = 0; i < 4; i++) step_up(3);
        cur_req = "R3 R9";
        for (int i = 0; i < 6; i++) step_dn(3);

        cur_req = "R5";
        step_up(2);
        step_up(3);
        cur_req = "R6";
        for (int i = 0; i < 3; i++) step_up(3);
        cyc(~a, ~b, 1'b0);
        idle(3);

        cur_req = "R7";
        cyc(a, b, 1'b1);
        idle(3);
        step_up(3);
        cyc(~b, a, 1'b1);
        idle(3);
        step_up(3);

        cur_req = "R4";
        cyc(~a, ~b, 1'b0);
        idle(3);
        cur_req = "R6";
        step_up(3);
        step_dn(3);
        cur_req = "R7";
        cyc(a, b, 1'b1);
        idle(2);

        cur_req = "R8";
        for (int i = 0; i < 33; i++) step_up(3);
        for (int i = 0; i < 2; i++) step_dn(3);

        cur_req = "R5";
        cyc(a, b, 1'b1);
        mg = 8'd1;
        for (int i = 0; i < 8; i++) step_up(1);
        for (int i = 0; i < 8; i++) step_dn(1);
        idle(3);

        wait (sb.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule